// File: doc/BRIEF.md
# Two-Wire Serial Memory Command Engine

This block is the bus-facing front end of a 4096-byte serial memory that answers on a two-wire clock/data bus. It receives the raw clock and data lines and passes each through a two-flop synchroniser. It then finds clock edges and bus START/STOP events in the system-clock domain. It drives a single pull-down enable for the open-drain data line. Its three strap inputs select which of eight bus addresses it answers to. When a command addresses this block, it collects the word address and acknowledges each byte. It then turns the command into single-cycle read or write requests on a plain synchronous memory port, where read data returns one clock after the request.

One 12-bit address pointer persists from one transaction to the next. A write command loads it from the two word-address bytes, and each access moves it forward. A read that carries no address therefore continues at the byte after the last one touched. Data bytes written in a row stay inside one 32-byte page. Reads run through the whole array and wrap from 0xFFF to 0x000. A START followed directly by a STOP abandons a command that is only partly received.

The controller has these states: ST_IDLE (waiting for a START), ST_DEVADDR (shifting in the address byte), ST_DEV_ACK, ST_WA_HI and ST_WA_HI_ACK, ST_WA_LO and ST_WA_LO_ACK, ST_WDATA and ST_WDATA_ACK, ST_RD_DATA (shifting out), ST_RD_ACK (sampling the master's answer), ST_RD_NEXT (master acknowledged, next byte fetched) and ST_WAIT (deaf until START or STOP). The transitions are as follows:
- A START from any state goes to ST_DEVADDR, and a STOP from any state goes to ST_IDLE.
- In ST_DEVADDR, after eight bits, an address match goes to ST_DEV_ACK and a mismatch goes to ST_WAIT.
- From ST_DEV_ACK, a read goes to ST_RD_DATA and a write goes to ST_WA_HI.
- The write path runs ST_WA_HI, then ST_WA_LO, then ST_WDATA. Each of these moves to its ACK state when eight bits are in, and returns to the next receive state on the clock's falling edge.
- ST_RD_DATA goes to ST_RD_ACK after eight bits. From ST_RD_ACK, a master ACK goes to ST_RD_NEXT and then back to ST_RD_DATA, while a master NACK goes to ST_WAIT.

Top module: `i2c_eeprom_engine`

## Requirements
- R1: The data pull-down enable changes only while the bus clock is low. Incoming data bits are taken at the clock's rising edge.
- R2: After reset, and until a START (data falling while clock is high) is seen, the block never pulls the data line, even when whole bytes are clocked past it.
- R3: The address byte is 1010, then the three strap bits (MSB first), then the read/write bit (1 = read). The block acknowledges by pulling data low in the ninth clock only on a match. On a mismatch it stays released for the rest of the transaction.
- R4: A write command carries two word-address bytes, and the block acknowledges both. The upper four bits of the first byte are ignored. The remaining 12 bits, high byte first, set the address pointer.
- R5: Each data byte of a write is acknowledged and issues one memory write at the pointer. The pointer's low 5 bits then advance and wrap inside the 32-byte page, while its upper 7 bits stay fixed.
- R6: A write header (address plus word address) followed by a repeated START and a read header returns data starting at that word address.
- R7: A read header with no word address returns the byte at the last accessed address plus one.
- R8: While the master acknowledges each read byte, the block sends the next byte in sequence. The pointer wraps from 0xFFF to 0x000.
- R9: A master NACK on a read byte ends output. The block then stays released on every further clock until START or STOP.
- R10: A START followed by a STOP during a partly received command abandons it. No memory write is issued and the pointer keeps its value.
- R11: After the eighth data bit of a read byte, the block releases the data line for the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap_i | input | 3 | Board-strapped device select bits |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| mem_rd_o | output | 1 | One-cycle read request |
| mem_wr_o | output | 1 | One-cycle write request |
| mem_addr_o | output | 12 | Memory address for the request |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |

## Verification
The bench targets the places where a persistent pointer is easy to get wrong. A page write that straddles the end of a 32-byte page would land in the next page if the wrap were missing. A read crossing 0xFFF would run past the array if the pointer were not masked. A current read after a write would return the wrong byte if the pointer advanced by the wrong amount or was reloaded. It also drives a START followed by a STOP in the middle of a word address. A design that committed a partial address there would move the pointer seen by the next current read. Finally, it clocks bytes with no START, with the wrong strap value, and after a master NACK. A design that answered any of these would show up as a low data line where the bus should float high.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_WA_HI,
        ST_WA_HI_ACK,
        ST_WA_LO,
        ST_WA_LO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_WAIT
    } eng_state_t;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/bus_line_mon.sv
module bus_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
            scl_prev <= scl_sh[STAGES-1];
            sda_prev <= sda_sh[STAGES-1];
        end
    end

    assign scl_now  = scl_sh[STAGES-1];
    assign sda_s    = sda_sh[STAGES-1];
    assign scl_rise = scl_now & ~scl_prev;
    assign scl_fall = ~scl_now & scl_prev;
    assign start_ev = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/mem_addr_ctr.sv
module mem_addr_ctr #(
    parameter int AW = 12,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_seq,
    input  logic          step_page,
    output logic [AW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step_page) begin
            cnt <= {cnt[AW-1:PW], cnt[PW-1:0] + 1'b1};
        end else if (step_seq) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_eeprom_engine.sv
module i2c_eeprom_engine
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_pull_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam int          HI_W     = ADDR_W - 8;
    localparam logic [3:0]  BITS_IN  = 4'd8;
    localparam logic [3:0]  LAST_OUT = 4'd7;

    eng_state_t        state_q, state_d;
    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0]        shreg_q;
    logic [3:0]        bitcnt_q;
    logic              rw_q;
    logic              pull_q;
    logic [HI_W-1:0]   wa_hi_q;
    logic [1:0]        load_pipe_q;
    logic [ADDR_W-1:0] ptr;
    logic              rd_go, wr_go, wa_ld;
    logic              byte_done, addr_match;

    bus_line_mon #(.STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    mem_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wa_ld),
        .load_val  ({wa_hi_q, shreg_q}),
        .step_seq  (rd_go),
        .step_page (wr_go),
        .cnt       (ptr)
    );

    assign byte_done  = scl_fall && (bitcnt_q == BITS_IN);
    assign addr_match = (shreg_q[7:4] == DEV_TYPE_CODE) && (shreg_q[3:1] == strap_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and memory request decode
    always_comb begin
        state_d = state_q;
        rd_go   = 1'b0;
        wr_go   = 1'b0;
        wa_ld   = 1'b0;
        if (start_ev) begin
            state_d = ST_DEVADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WAIT: state_d = state_q;
                ST_DEVADDR: if (byte_done) begin
                    if (addr_match) begin
                        state_d = ST_DEV_ACK;
                        rd_go   = shreg_q[0];
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
                ST_DEV_ACK:   if (scl_fall) state_d = rw_q ? ST_RD_DATA : ST_WA_HI;
                ST_WA_HI:     if (byte_done) state_d = ST_WA_HI_ACK;
                ST_WA_HI_ACK: if (scl_fall) state_d = ST_WA_LO;
                ST_WA_LO: if (byte_done) begin
                    state_d = ST_WA_LO_ACK;
                    wa_ld   = 1'b1;
                end
                ST_WA_LO_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA: if (byte_done) begin
                    state_d = ST_WDATA_ACK;
                    wr_go   = 1'b1;
                end
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RD_DATA:   if (scl_fall && bitcnt_q == LAST_OUT) state_d = ST_RD_ACK;
                ST_RD_ACK: if (scl_rise) begin
                    if (sda_s) begin
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_RD_NEXT;
                        rd_go   = 1'b1;
                    end
                end
                ST_RD_NEXT:   if (scl_fall) state_d = ST_RD_DATA;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            bitcnt_q    <= '0;
            rw_q        <= 1'b0;
            pull_q      <= 1'b0;
            wa_hi_q     <= '0;
            load_pipe_q <= '0;
            mem_rd_o    <= 1'b0;
            mem_wr_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
        end else begin
            mem_rd_o    <= rd_go;
            mem_wr_o    <= wr_go;
            load_pipe_q <= {load_pipe_q[0], rd_go};
            if (rd_go || wr_go) mem_addr_o <= ptr;
            if (wr_go) mem_wdata_o <= shreg_q;

            if (start_ev || stop_ev) begin
                bitcnt_q <= '0;
                pull_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_DEVADDR, ST_WA_HI, ST_WA_LO, ST_WDATA: begin
                        if (scl_rise && bitcnt_q != BITS_IN) begin
                            shreg_q  <= {shreg_q[6:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (byte_done) begin
                            bitcnt_q <= '0;
                            pull_q   <= (state_q != ST_DEVADDR) || addr_match;
                            if (state_q == ST_DEVADDR) rw_q <= shreg_q[0];
                            if (state_q == ST_WA_HI) wa_hi_q <= shreg_q[HI_W-1:0];
                        end
                    end
                    ST_DEV_ACK, ST_WA_HI_ACK, ST_WA_LO_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            pull_q   <= (state_q == ST_DEV_ACK && rw_q) ? ~shreg_q[7] : 1'b0;
                            bitcnt_q <= '0;
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_fall) begin
                            if (bitcnt_q == LAST_OUT) begin
                                pull_q   <= 1'b0;
                                bitcnt_q <= '0;
                            end else begin
                                shreg_q  <= {shreg_q[6:0], 1'b0};
                                pull_q   <= ~shreg_q[6];
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RD_NEXT: begin
                        if (scl_fall) begin
                            pull_q   <= ~shreg_q[7];
                            bitcnt_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end

            if (load_pipe_q[1]) shreg_q <= mem_rdata_i;
        end
    end

    assign sda_pull_o = pull_q;

endmodule

// File: rtl/i2c_eeprom_engine_chk.sv
module i2c_eeprom_engine_chk
    import i2c_eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input eng_state_t state
);
    p_pull_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);

    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    p_wait_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_pull_o);

endmodule

bind i2c_eeprom_engine i2c_eeprom_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .state      (state_q)
);

// File: tb/i2c_eeprom_engine_bench.sv
module i2c_eeprom_engine_bench;
    localparam int         QT    = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_pull;
    logic        mem_rd, mem_wr;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    wire         sda_line = m_sda & ~sda_pull;

    int n_chk = 0;
    int n_fail = 0;
    int wr_count = 0;
    int r1_viol = 0;
    bit done = 1'b0;
    logic [11:0] mcnt = 12'h000;
    logic [7:0]  wbuf [8];
    logic [7:0]  store   [int unsigned];
    logic [7:0]  exp_mem [int unsigned];
    logic        pull_prev = 1'b0;

    always #4 clk = ~clk;

    i2c_eeprom_engine u_i2c_eeprom_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .strap_i     (STRAP),
        .sda_pull_o  (sda_pull),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    function automatic logic [7:0] init_pat(int unsigned a);
        return 8'((a * 7) + (a >> 8) + 8'h3C);
    endfunction

    function automatic logic [7:0] exp_byte(logic [11:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_pat(a);
    endfunction

    function automatic logic [11:0] page_next(logic [11:0] a);
        return {a[11:5], a[4:0] + 5'd1};
    endfunction

    // Memory model behind the port
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : init_pat(mem_addr);
        if (mem_wr) begin
            store[int'(mem_addr)] = mem_wdata;
            wr_count++;
        end
    end

    // R1 monitor: pull-down must not move while the clock line is high
    always @(posedge clk) begin
        if (rst_n && (sda_pull != pull_prev) && m_scl) r1_viol++;
        pull_prev <= sda_pull;
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QT) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(logic [7:0] d, output int ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = (b == 1'b0) ? 1 : 0;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit mack, output logic ackline);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        m_sda = ~mack; wq();
        m_scl = 1'b1; wq();
        ackline = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic header_wr(logic [11:0] addr, logic [3:0] junk);
        int a;
        bus_start();
        send_byte({4'hA, STRAP, 1'b0}, a); chk("R3 address ack (write)", a, 1);
        send_byte({junk, addr[11:8]}, a);  chk("R4 word address high ack", a, 1);
        send_byte(addr[7:0], a);           chk("R4 word address low ack", a, 1);
        mcnt = addr;
    endtask

    task automatic read_seq(int n, string tag);
        logic [7:0] d;
        logic al;
        for (int i = 0; i < n; i++) begin
            recv_byte(d, (i != n - 1), al);
            chk(tag, int'(d), int'(exp_byte(mcnt)));
            mcnt = mcnt + 12'd1;
            if (i == n - 1) chk("R11 line released at ack clock", int'(al), 1);
        end
    endtask

    task automatic do_write(logic [11:0] addr, int n, logic [3:0] junk);
        int a;
        header_wr(addr, junk);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk("R5 data byte ack", a, 1);
            exp_mem[int'(mcnt)] = wbuf[i];
            mcnt = page_next(mcnt);
        end
        bus_stop();
    endtask

    task automatic do_rand_read(logic [11:0] addr, int n, string tag);
        int a;
        header_wr(addr, 4'h0);
        bus_start();
        send_byte({4'hA, STRAP, 1'b1}, a); chk("R6 address ack (read)", a, 1);
        read_seq(n, tag);
        bus_stop();
    endtask

    task automatic do_cur_read(int n, string tag);
        int a;
        bus_start();
        send_byte({4'hA, STRAP, 1'b1}, a); chk("R7 address ack (current read)", a, 1);
        read_seq(n, tag);
        bus_stop();
    endtask

    initial begin : main
        int a;
        int wc;
        logic b;
        logic [7:0] d;
        logic al;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        chk("R2 reset: pull released", int'(sda_pull), 0);
        chk("R2 reset: no read request", int'(mem_rd), 0);
        chk("R2 reset: no write request", int'(mem_wr), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: bytes with no START are ignored
        m_scl = 1'b0; wq();
        send_byte({4'hA, STRAP, 1'b0}, a); chk("R2 no ack before START", a, 0);
        send_byte(8'h00, a);               chk("R2 still ignored", a, 0);
        m_scl = 1'b1; wq();

        // R3: strap mismatch
        bus_start();
        send_byte({4'hA, STRAP ^ 3'b010, 1'b0}, a); chk("R3 mismatch no ack", a, 0);
        send_byte(8'h12, a);                        chk("R3 rest ignored", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'hB, STRAP, 1'b1}, a); chk("R3 wrong type code no ack", a, 0);
        bus_stop();

        // R4/R5: write inside a page with junk upper nibble, read back
        wbuf[0] = 8'hC1; wbuf[1] = 8'h5A; wbuf[2] = 8'h07;
        do_write(12'h05C, 3, 4'hF);
        do_rand_read(12'h05C, 3, "R6 random read data");
        do_cur_read(1, "R7 current read data");

        // R5: page wrap 0x7E,0x7F,0x60
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        do_write(12'h07E, 3, 4'h9);
        do_rand_read(12'h060, 1, "R5 page wrapped byte at 0x060");
        do_rand_read(12'h07E, 3, "R5 page tail and 0x080 untouched");

        // R7: current read after write
        wbuf[0] = 8'h3D;
        do_write(12'h200, 1, 4'h0);
        do_cur_read(2, "R7 current read after write");

        // R8: wrap of the pointer at the top of the array
        do_rand_read(12'hFFE, 4, "R8 sequential read across 0xFFF");

        // R9/R11: NACK ends output, further clocks see released line
        do_rand_read(12'h123, 1, "R9 single byte before NACK");
        bus_start();
        send_byte({4'hA, STRAP, 1'b1}, a); chk("R9 address ack", a, 1);
        recv_byte(d, 1'b0, al);
        chk("R9 byte data", int'(d), int'(exp_byte(mcnt)));
        chk("R11 released for NACK", int'(al), 1);
        mcnt = mcnt + 12'd1;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            chk("R9 line stays high after NACK", int'(b), 1);
        end
        bus_stop();
        do_cur_read(1, "R9 pointer after NACK read");

        // R10: abort mid word address and mid address byte
        wc = wr_count;
        bus_start();
        send_byte({4'hA, STRAP, 1'b0}, a); chk("R10 address ack", a, 1);
        send_byte(8'h03, a);               chk("R10 high byte ack", a, 1);
        bus_start();
        bus_stop();
        bus_start();
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        bus_stop();
        chk("R10 no write issued", wr_count, wc);
        do_cur_read(1, "R10 pointer unchanged after abort");

        // Random mix
        for (int it = 0; it < 10; it++) begin
            logic [11:0] ra;
            int n;
            ra = 12'($urandom);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(ra, n, 4'($urandom));
            do_rand_read(ra, n + 1, "R6 random readback");
            if ($urandom % 2 == 1) do_cur_read(2, "R7 random current read");
        end

        chk("R1 pull changed only while clock low", r1_viol, 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule